// File: doc/BRIEF.md
# Powerdown Entry and Wake Controller

This block holds a processor core in a low-power state and decides when the core may run again. A one-cycle strobe from the instruction decoder, raised when the core retires its powerdown instruction, moves the block into powerdown. While it is in powerdown, the block drops the clock-run enable that gates the core clock. The block itself stays clocked the whole time and keeps watching two wake sources: the hardware reset line and a bank of four external interrupt lines.

In powerdown the interrupt lines are treated as levels. A line counts only if its pin is configured for its special function. The line's interrupt enable does not matter for waking. Every line that is high at the wake edge sets its pending bit. Each pending and enabled line is then offered to the core for service, one at a time, over a valid/ready request channel. Once all of them are accepted, a one-cycle resume strobe tells the core to continue after the powerdown instruction. If no waking line is enabled, the resume strobe fires at once and the pending bits stay set until software clears them.

A reset counts as a wake only when it is qualified. With the PLL or an external clock source, the reset line must be held low for a fixed number of consecutive cycles. With the on-chip oscillator, it must be held low until the oscillator reports that it is stable. A qualified reset wake clears every pending bit and returns the block to run without a resume strobe.

Top module: `pwrdn_wake_ctrl`

## Requirements
- R1: When `pd_cmd` is high at a clock edge while the block runs and `rst_n` is high, `clk_run` is low after that edge. `pd_cmd` has no effect while `rst_n` is low or while a service request is in progress.
- R2: While in powerdown, `clk_run` stays low until a qualified reset or a qualifying interrupt line is seen. No other input changes that.
- R3: With `osc_mode` = 0 (PLL or external clock), a reset wake happens at the edge where `rst_n` is sampled low for the 16th consecutive powerdown cycle. A high sample restarts the count. Interrupt lines are ignored while `rst_n` is low in powerdown.
- R4: With `osc_mode` = 1 (on-chip oscillator), a reset wake happens at the first powerdown edge where `rst_n` is low and `osc_stable` is high. The cycle count does not matter in this mode.
- R5: After a reset wake, `clk_run` is high, all `pend` bits are 0, `svc_valid` is low and `resume` stays low.
- R6: Line i qualifies at a powerdown edge when `ext_int[i]` and `sfn_cfg[i]` are both high, whatever the value of `int_en[i]`. This includes a line already high before powerdown was entered. A line with `sfn_cfg[i]` = 0 never wakes the block.
- R7: At an interrupt wake edge, `pend[i]` is set for every qualifying line i in the same cycle.
- R8: If no qualifying line has its `int_en` bit set, the next cycle shows `clk_run` high, `svc_valid` low and a one-cycle `resume` pulse. The pending bits stay set.
- R9: If some qualifying lines are enabled, `svc_valid` rises after the wake edge, and `svc_idx` gives the binary index of the lowest-numbered enabled woken line still waiting. `svc_valid` and `svc_idx` hold until `svc_ready`. Each accepted request clears that line's `pend` bit. After the last one is accepted, `resume` pulses for one cycle and `svc_valid` falls.
- R10: `pend_clr[i]` high at an edge clears `pend[i]` after it. A set of the same bit at the same edge wins over the clear.
- R11: `rst_n` low while running or serving clears all `pend` bits, drops `svc_valid` and returns to run with no `resume` pulse.
- R12: `por_n` low resets the block asynchronously to run: `clk_run` high, `pend` 0, `svc_valid` low, `resume` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running clock of the controller |
| por_n | input | 1 | Asynchronous power-on reset of the controller, active low |
| rst_n | input | 1 | Hardware reset line, active low, sampled synchronously |
| pd_cmd | input | 1 | One-cycle strobe: powerdown instruction executed |
| ext_int | input | 4 | External interrupt lines, active high |
| sfn_cfg | input | 4 | Per-line special-function pin configuration |
| int_en | input | 4 | Per-line interrupt enable |
| osc_mode | input | 1 | 1: on-chip oscillator; 0: PLL or external clock |
| osc_stable | input | 1 | Oscillator and PLL stable indication |
| pend_clr | input | 4 | Software clear strobe, one bit per pending flag |
| svc_ready | input | 1 | Core accepts the current service request |
| clk_run | output | 1 | Core clock enable, low in powerdown |
| pend | output | 4 | Interrupt pending bits |
| svc_valid | output | 1 | Service request valid |
| svc_idx | output | 2 | Index of the line requesting service |
| resume | output | 1 | One-cycle strobe: continue after the powerdown instruction |

## Verification
The bench targets the exact edge of a reset wake in counted mode. It releases the reset after ten cycles to catch a counter that is not restarted, and it checks the 15th and 16th low samples to catch an off-by-one wake. It holds reset low with the oscillator unstable for longer than the count, to expose a design that applies the cycle count in oscillator mode. It drives a line on an unconfigured pin, an enabled wake with two waiting lines under back-pressure, and a clear that collides with a set. A wrong design would wake on a masked-out pin, change the index while the request is stalled, or lose a pending bit. It also asserts reset during service and hands in a powerdown strobe while reset is low, both of which must leave the core running.

// File: rtl/pwrdn_wake_pkg.sv
package pwrdn_wake_pkg;
  typedef enum logic [1:0] {
    ST_RUN = 2'd0,
    ST_PD  = 2'd1,
    ST_SVC = 2'd2
  } pdw_state_e;
endpackage

// File: rtl/pdw_rst_qual.sv
// Qualifies the hardware reset line as a wake source while in powerdown.
module pdw_rst_qual #(
  parameter int QUAL_CYCLES = 16,
  localparam int CNT_W = (QUAL_CYCLES > 1) ? $clog2(QUAL_CYCLES) : 1
) (
  input  logic clk,
  input  logic por_n,
  input  logic in_pd,
  input  logic rst_n,
  input  logic osc_mode,
  input  logic osc_stable,
  output logic rst_wake
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(QUAL_CYCLES - 1);

  logic [CNT_W-1:0] low_cnt_q;
  logic             low_seen;
  logic             count_done;

  assign low_seen   = in_pd && !rst_n;
  assign count_done = (low_cnt_q == LAST);
  assign rst_wake   = low_seen && (osc_mode ? osc_stable : count_done);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      low_cnt_q <= '0;
    end else if (!low_seen || rst_wake) begin
      low_cnt_q <= '0;
    end else if (!count_done) begin
      low_cnt_q <= low_cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/pdw_line_qual.sv
// Per-line wake qualification: level, special-function pin, arm window.
module pdw_line_qual #(
  parameter int N_LINES = 4
) (
  input  logic               arm,
  input  logic [N_LINES-1:0] ext_int,
  input  logic [N_LINES-1:0] sfn_cfg,
  input  logic [N_LINES-1:0] int_en,
  output logic [N_LINES-1:0] hit,
  output logic [N_LINES-1:0] hit_en,
  output logic               any_hit,
  output logic               any_hit_en
);
  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    assign hit[i]    = arm && ext_int[i] && sfn_cfg[i];
    assign hit_en[i] = hit[i] && int_en[i];
  end
  assign any_hit    = |hit;
  assign any_hit_en = |hit_en;
endmodule

// File: rtl/pdw_pick_low.sv
// Lowest-index selector for the service queue.
module pdw_pick_low #(
  parameter int N_LINES = 4,
  localparam int IDX_W = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
  input  logic [N_LINES-1:0] req,
  output logic [N_LINES-1:0] onehot,
  output logic [IDX_W-1:0]   idx,
  output logic               any
);
  always_comb begin
    onehot = '0;
    idx    = '0;
    for (int i = N_LINES - 1; i >= 0; i--) begin
      if (req[i]) begin
        onehot    = '0;
        onehot[i] = 1'b1;
        idx       = IDX_W'(i);
      end
    end
  end
  assign any = |req;
endmodule

// File: rtl/pdw_pend_bank.sv
// Pending flags: set beats clear; clear_all beats both.
module pdw_pend_bank #(
  parameter int N_LINES = 4
) (
  input  logic               clk,
  input  logic               por_n,
  input  logic               clear_all,
  input  logic [N_LINES-1:0] set_bits,
  input  logic [N_LINES-1:0] drop_bits,
  output logic [N_LINES-1:0] pend_q
);
  for (genvar i = 0; i < N_LINES; i++) begin : g_bit
    always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
        pend_q[i] <= 1'b0;
      end else if (clear_all) begin
        pend_q[i] <= 1'b0;
      end else if (set_bits[i]) begin
        pend_q[i] <= 1'b1;
      end else if (drop_bits[i]) begin
        pend_q[i] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pwrdn_wake_ctrl.sv
module pwrdn_wake_ctrl
  import pwrdn_wake_pkg::*;
#(
  parameter int N_LINES         = 4,
  parameter int RST_QUAL_CYCLES = 16,
  localparam int IDX_W = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
  input  logic               clk,
  input  logic               por_n,
  input  logic               rst_n,
  input  logic               pd_cmd,
  input  logic [N_LINES-1:0] ext_int,
  input  logic [N_LINES-1:0] sfn_cfg,
  input  logic [N_LINES-1:0] int_en,
  input  logic               osc_mode,
  input  logic               osc_stable,
  input  logic [N_LINES-1:0] pend_clr,
  input  logic               svc_ready,
  output logic               clk_run,
  output logic [N_LINES-1:0] pend,
  output logic               svc_valid,
  output logic [IDX_W-1:0]   svc_idx,
  output logic               resume
);
  pdw_state_e         st_q, st_d;
  logic               in_pd, in_svc;
  logic               rst_wake;
  logic [N_LINES-1:0] line_hit, line_hit_en;
  logic               any_hit, any_hit_en;
  logic [N_LINES-1:0] svc_mask_q, svc_onehot;
  logic               svc_any;
  logic               handshake, last_done, masked_wake;
  logic               clear_all;
  logic [N_LINES-1:0] drop_bits;
  logic               resume_q;

  assign in_pd  = (st_q == ST_PD);
  assign in_svc = (st_q == ST_SVC);

  pdw_rst_qual #(.QUAL_CYCLES(RST_QUAL_CYCLES)) u_rqual (
    .clk        (clk),
    .por_n      (por_n),
    .in_pd      (in_pd),
    .rst_n      (rst_n),
    .osc_mode   (osc_mode),
    .osc_stable (osc_stable),
    .rst_wake   (rst_wake)
  );

  pdw_line_qual #(.N_LINES(N_LINES)) u_lqual (
    .arm        (in_pd && rst_n),
    .ext_int    (ext_int),
    .sfn_cfg    (sfn_cfg),
    .int_en     (int_en),
    .hit        (line_hit),
    .hit_en     (line_hit_en),
    .any_hit    (any_hit),
    .any_hit_en (any_hit_en)
  );

  pdw_pick_low #(.N_LINES(N_LINES)) u_pick (
    .req    (svc_mask_q),
    .onehot (svc_onehot),
    .idx    (svc_idx),
    .any    (svc_any)
  );

  assign handshake   = in_svc && rst_n && svc_any && svc_ready;
  assign last_done   = handshake && (svc_mask_q == svc_onehot);
  assign masked_wake = any_hit && !any_hit_en;
  assign clear_all   = rst_wake || (!rst_n && !in_pd);
  assign drop_bits   = pend_clr | (handshake ? svc_onehot : '0);

  pdw_pend_bank #(.N_LINES(N_LINES)) u_pend (
    .clk       (clk),
    .por_n     (por_n),
    .clear_all (clear_all),
    .set_bits  (line_hit),
    .drop_bits (drop_bits),
    .pend_q    (pend)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_RUN: if (rst_n && pd_cmd) st_d = ST_PD;
      ST_PD: begin
        if (rst_wake)        st_d = ST_RUN;
        else if (any_hit_en) st_d = ST_SVC;
        else if (any_hit)    st_d = ST_RUN;
      end
      ST_SVC: if (!rst_n || last_done) st_d = ST_RUN;
      default: st_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      st_q       <= ST_RUN;
      svc_mask_q <= '0;
      resume_q   <= 1'b0;
    end else begin
      st_q     <= st_d;
      resume_q <= masked_wake || last_done;
      if (clear_all)       svc_mask_q <= '0;
      else if (any_hit_en) svc_mask_q <= line_hit_en;
      else if (handshake)  svc_mask_q <= svc_mask_q & ~svc_onehot;
    end
  end

  assign clk_run   = !in_pd;
  assign svc_valid = in_svc && svc_any;
  assign resume    = resume_q;
endmodule

// File: rtl/pwrdn_wake_ctrl_chk.sv
module pwrdn_wake_ctrl_chk #(
  parameter int N_LINES         = 4,
  parameter int RST_QUAL_CYCLES = 16,
  localparam int IDX_W = (N_LINES > 1) ? $clog2(N_LINES) : 1,
  localparam int LW    = $clog2(RST_QUAL_CYCLES + 1) + 1
) (
  input logic               clk,
  input logic               por_n,
  input logic               rst_n,
  input logic               pd_cmd,
  input logic [N_LINES-1:0] ext_int,
  input logic [N_LINES-1:0] sfn_cfg,
  input logic [N_LINES-1:0] int_en,
  input logic               osc_mode,
  input logic               osc_stable,
  input logic [N_LINES-1:0] pend_clr,
  input logic               svc_ready,
  input logic               clk_run,
  input logic [N_LINES-1:0] pend,
  input logic               svc_valid,
  input logic [IDX_W-1:0]   svc_idx,
  input logic               resume
);
  logic [LW-1:0] low_run;
  logic [N_LINES-1:0] wk;
  assign wk = ext_int & sfn_cfg;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) low_run <= '0;
    else if (!clk_run && !rst_n) begin
      if (low_run < LW'(RST_QUAL_CYCLES)) low_run <= low_run + LW'(1);
    end else low_run <= '0;
  end

  p_stay_run_r1: assert property (@(posedge clk) disable iff (!por_n)
    (clk_run && !pd_cmd) |=> clk_run);
  p_no_stray_wake_r2: assert property (@(posedge clk) disable iff (!por_n)
    (!clk_run && rst_n && (wk == '0)) |=> !clk_run);
  p_count_hold_r3: assert property (@(posedge clk) disable iff (!por_n)
    (!clk_run && !osc_mode && !rst_n && (low_run < LW'(RST_QUAL_CYCLES - 1))) |=> !clk_run);
  p_osc_hold_r4: assert property (@(posedge clk) disable iff (!por_n)
    (!clk_run && osc_mode && !rst_n && !osc_stable) |=> !clk_run);
  p_osc_wake_r5: assert property (@(posedge clk) disable iff (!por_n)
    (!clk_run && osc_mode && !rst_n && osc_stable) |=> (clk_run && pend == '0 && !resume && !svc_valid));
  p_pend_set_r7: assert property (@(posedge clk) disable iff (!por_n)
    (!clk_run && rst_n && (wk != '0)) |=> ((pend & $past(wk)) == $past(wk)));
  p_masked_resume_r8: assert property (@(posedge clk) disable iff (!por_n)
    (!clk_run && rst_n && (wk != '0) && ((wk & int_en) == '0)) |=> (clk_run && resume && !svc_valid));
  p_req_hold_r9: assert property (@(posedge clk) disable iff (!por_n)
    (svc_valid && !svc_ready && rst_n) |=> (svc_valid && $stable(svc_idx)));
  p_resume_pulse_r9: assert property (@(posedge clk) disable iff (!por_n)
    resume |=> !resume);
  p_sw_clear_r10: assert property (@(posedge clk) disable iff (!por_n)
    (clk_run && rst_n && !svc_valid && (pend_clr != '0)) |=> ((pend & $past(pend_clr)) == '0));
  p_run_reset_r11: assert property (@(posedge clk) disable iff (!por_n)
    (clk_run && !rst_n) |=> (clk_run && pend == '0 && !svc_valid && !resume));
endmodule

bind pwrdn_wake_ctrl pwrdn_wake_ctrl_chk #(
  .N_LINES(N_LINES), .RST_QUAL_CYCLES(RST_QUAL_CYCLES)
) u_chk (
  .clk(clk), .por_n(por_n), .rst_n(rst_n), .pd_cmd(pd_cmd), .ext_int(ext_int),
  .sfn_cfg(sfn_cfg), .int_en(int_en), .osc_mode(osc_mode), .osc_stable(osc_stable),
  .pend_clr(pend_clr), .svc_ready(svc_ready), .clk_run(clk_run), .pend(pend),
  .svc_valid(svc_valid), .svc_idx(svc_idx), .resume(resume)
);

// File: tb/sim_pwrdn_wake_ctrl.sv
`timescale 1ns/1ps
module sim_pwrdn_wake_ctrl;
  logic clk = 1'b0;
  logic por_n = 1'b0, rst_n = 1'b1, pd_cmd = 1'b0;
  logic [3:0] ext_int = '0, sfn_cfg = '0, int_en = '0, pend_clr = '0;
  logic osc_mode = 1'b0, osc_stable = 1'b0, svc_ready = 1'b0;
  logic clk_run, svc_valid, resume;
  logic [3:0] pend;
  logic [1:0] svc_idx;

  int vectors = 0, miscompares = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pwrdn_wake_ctrl u0 (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .pd_cmd(pd_cmd), .ext_int(ext_int),
    .sfn_cfg(sfn_cfg), .int_en(int_en), .osc_mode(osc_mode), .osc_stable(osc_stable),
    .pend_clr(pend_clr), .svc_ready(svc_ready), .clk_run(clk_run), .pend(pend),
    .svc_valid(svc_valid), .svc_idx(svc_idx), .resume(resume)
  );

  // Behavioural reference: 0 run, 1 powerdown, 2 serving.
  int m_st = 0, m_cnt = 0;
  logic [3:0] m_pend = '0, m_wait = '0;
  bit m_res = 1'b0;

  function automatic int lowest(input logic [3:0] v);
    for (int i = 0; i < 4; i++) if (v[i]) return i;
    return 0;
  endfunction

  always @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      m_st = 0; m_cnt = 0; m_pend = '0; m_wait = '0; m_res = 1'b0;
    end else begin
      logic [3:0] hits;
      int k;
      hits = ext_int & sfn_cfg;
      m_res = 1'b0;
      if (m_st == 0) begin
        if (!rst_n) begin m_pend = '0; m_wait = '0; end
        else begin m_pend = m_pend & ~pend_clr; if (pd_cmd) begin m_st = 1; m_cnt = 0; end end
      end else if (m_st == 1) begin
        if (!rst_n) begin
          m_cnt++;
          if (osc_mode ? osc_stable : (m_cnt >= 16)) begin
            m_st = 0; m_pend = '0; m_wait = '0; m_cnt = 0;
          end else m_pend = m_pend & ~pend_clr;
        end else begin
          m_cnt = 0;
          m_pend = (m_pend & ~pend_clr) | hits;
          if ((hits & int_en) != 0) begin m_st = 2; m_wait = hits & int_en; end
          else if (hits != 0) begin m_st = 0; m_res = 1'b1; end
        end
      end else begin
        if (!rst_n) begin m_st = 0; m_pend = '0; m_wait = '0; end
        else begin
          m_pend = m_pend & ~pend_clr;
          if (svc_ready) begin
            k = lowest(m_wait);
            m_pend[k] = 1'b0; m_wait[k] = 1'b0;
            if (m_wait == 0) begin m_st = 0; m_res = 1'b1; end
          end
        end
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (por_n && !done) begin
    chk("R2 clk_run vs model", clk_run, (m_st != 1));
    chk("R7 pend vs model", pend, m_pend);
    chk("R9 svc_valid vs model", svc_valid, (m_st == 2));
    if (m_st == 2) chk("R9 svc_idx vs model", svc_idx, lowest(m_wait));
    chk("R8 resume vs model", resume, m_res);
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    step(2);
    chk("R12 clk_run in por", clk_run, 1);
    chk("R12 pend in por", pend, 0);
    chk("R12 svc_valid in por", svc_valid, 0);
    chk("R12 resume in por", resume, 0);
    por_n = 1'b1;
    step(2);

    // Entry, then stray activity on an unconfigured pin.
    pd_cmd = 1; step(1); pd_cmd = 0;
    chk("R1 enter powerdown", clk_run, 0);
    ext_int = 4'b1000; sfn_cfg = 4'b0111; step(5);
    chk("R6 unconfigured pin ignored", clk_run, 0);
    chk("R2 still asleep", pend, 0);

    // Masked wake on two lines.
    ext_int = 4'b0110; sfn_cfg = 4'b0110; int_en = 0; step(1); ext_int = 0;
    chk("R8 masked wake run", clk_run, 1);
    chk("R8 masked wake resume", resume, 1);
    chk("R7 both pending", pend, 4'b0110);
    step(1);
    chk("R8 resume single cycle", resume, 0);
    pend_clr = 4'b0010; step(1); pend_clr = 0;
    chk("R10 software clear", pend, 4'b0100);

    // Enabled wake with back-pressure.
    pd_cmd = 1; step(1); pd_cmd = 0;
    int_en = 4'b1010; sfn_cfg = 4'b1111; ext_int = 4'b1011; step(1); ext_int = 0;
    chk("R9 request valid", svc_valid, 1);
    chk("R9 first index", svc_idx, 1);
    chk("R7 pend after enabled wake", pend, 4'b1111);
    step(2);
    chk("R9 held under stall", svc_valid, 1);
    chk("R9 index held", svc_idx, 1);
    svc_ready = 1; step(1);
    chk("R9 next index", svc_idx, 3);
    chk("R9 accepted bit cleared", pend, 4'b1101);
    step(1); svc_ready = 0;
    chk("R9 resume after last", resume, 1);
    chk("R9 valid dropped", svc_valid, 0);
    chk("R9 remaining pending", pend, 4'b0101);
    step(1);

    // Set beats clear at the same edge.
    int_en = 0;
    pd_cmd = 1; step(1); pd_cmd = 0;
    ext_int = 4'b0001; pend_clr = 4'b0001; step(1); ext_int = 0; pend_clr = 0;
    chk("R10 set wins over clear", pend, 4'b0101);
    step(1);

    // Counted reset qualification.
    osc_mode = 0;
    pd_cmd = 1; step(1); pd_cmd = 0;
    rst_n = 0; step(10); rst_n = 1; step(1);
    chk("R3 short reset no wake", clk_run, 0);
    rst_n = 0; ext_int = 4'b1111; step(15);
    chk("R3 fifteen lows still asleep", clk_run, 0);
    step(1);
    chk("R3 sixteenth low wakes", clk_run, 1);
    chk("R5 reset wake clears pending", pend, 0);
    chk("R5 no resume on reset wake", resume, 0);
    rst_n = 1; ext_int = 0; step(2);

    // Oscillator-mode qualification.
    osc_mode = 1; osc_stable = 0;
    pd_cmd = 1; step(1); pd_cmd = 0;
    rst_n = 0; step(20);
    chk("R4 unstable oscillator holds", clk_run, 0);
    osc_stable = 1; step(1);
    chk("R4 stable oscillator wakes", clk_run, 1);
    rst_n = 1; osc_stable = 0; step(2);

    // Reset during service; strobe ignored under reset.
    pd_cmd = 1; step(1); pd_cmd = 0;
    int_en = 4'b0001; sfn_cfg = 4'b0001; ext_int = 4'b0001; step(1); ext_int = 0;
    chk("R9 service pending", svc_valid, 1);
    rst_n = 0; step(1);
    chk("R11 reset drops request", svc_valid, 0);
    chk("R11 reset clears pending", pend, 0);
    chk("R11 no resume", resume, 0);
    pd_cmd = 1; step(1); pd_cmd = 0;
    chk("R1 strobe ignored under reset", clk_run, 1);
    rst_n = 1; int_en = 0; step(1);

    // Line already high before entry.
    ext_int = 4'b0100; sfn_cfg = 4'b0100;
    pd_cmd = 1; step(1); pd_cmd = 0;
    chk("R6 entry with line high", clk_run, 0);
    step(1); ext_int = 0;
    chk("R6 level wake", clk_run, 1);
    chk("R7 level wake pending", pend, 4'b0100);
    step(3);
    finish_run();
  end
endmodule